// File: doc/BRIEF.md
# Frequency Synthesizer Two-Wire Control Slave

This block is the serial control front end of a tuning synthesizer. A host on a two-wire I2C bus writes a 15-bit loop divider ratio and a set of control flags, and reads back a status byte that reports the loop lock indication, two logic-level port inputs, a 3-bit converter code and a power-on flag. Both bus lines are oversampled by the system clock, so start, stop and clock edges are recovered as single-cycle events in that domain. The open-drain pad lives outside: the block only requests that SDA be pulled low.

A write telegram carries byte pairs after the address. The leading bit of the first byte of a pair selects the pair type: 0 for the divider, 1 for control. The second byte of a pair is taken as the same type whatever its leading bit. A pair that is cut short by a stop or a new start is dropped. A read telegram returns the same latched status byte for as long as the host acknowledges each byte. The power-on flag stays set until a read telegram is closed by a stop.

Top module: `synth_ctl_i2c`

## Requirements
- R1: A falling SDA while SCL is high begins a telegram. A rising SDA while SCL is high ends it. Data bits are taken on rising SCL, most significant bit first.
- R2: The address byte is 1,1,0,0,0,S1,S0,RW, where S1:S0 must equal `addr_sel` and RW=1 selects a read. Any other address gets no acknowledge, and the block then ignores the rest of the telegram. The block changes its SDA request only after a falling SCL.
- R3: Every matching address byte, and every data byte of a write, is acknowledged by holding SDA low for the whole ninth clock.
- R4: A first byte with bit 7 = 0 carries divider bits 14..8 in its bits 6..0, and the next byte carries bits 7..0. `divider` changes only when the acknowledge of the second byte ends, never between the two bytes.
- R5: A first byte with bit 7 = 1 is control byte one, with bit 6 as `pump_hi`, bit 5 as `test_route`, bit 4 as `cp_float` and bit 0 as `tune_off`. The following byte is control byte two, with bit 4 as `band_b` and bits 2..0 as `port_on[2:0]`. Both bytes take effect together when the acknowledge of byte two ends. A `port_on` bit of 1 turns on that open-collector output.
- R6: A pair whose first byte is followed by a stop is discarded. After a complete pair, the next byte opens a new pair of either type.
- R7: After acknowledging a read address, the block shifts out the status byte {POR, lock_in, 0, ttl_in[1], ttl_in[0], adc_code[2:0]} (bit 7 first).
- R8: The status byte is sent again each time the host acknowledges. After a not-acknowledge, SDA is left released until the next start or stop.
- R9: The status byte is captured when the address byte completes. Input changes during the read telegram do not alter the bytes sent in it.
- R10: POR is 1 after reset and whenever `supply_low` is high. It clears on a stop that ends a read telegram. Write telegrams leave it unchanged.
- R11: While `rst_n` is low, the block never pulls SDA low. After reset, `divider`, all control outputs and `port_on` are 0.
- R12: A start in the middle of a telegram restarts address decoding and discards a half-received pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_sel | input | 2 | Pin-selected low address bits |
| ttl_in | input | 2 | Logic-level port inputs reported in status |
| adc_code | input | 3 | Converter level code reported in status |
| lock_in | input | 1 | Loop lock indication reported in status |
| supply_low | input | 1 | Supply-low detect, sets POR |
| sda_drive_low | output | 1 | Request to pull SDA low |
| divider | output | 15 | Loop divider ratio |
| pump_hi | output | 1 | High pump current select |
| test_route | output | 1 | Route test signals to ports |
| cp_float | output | 1 | Pump output to high impedance |
| tune_off | output | 1 | Disable tuning output |
| band_b | output | 1 | Select the second band |
| port_on | output | 3 | Open-collector port output enables |

## Verification
Two events can meet on the same SCL falling edge: the end of the acknowledge of a second pair byte, which commits a register, and the start of the next byte. A read telegram can also end with the POR clear on the same stop that releases the bus. The bench runs divider and control pairs back to back in one telegram, with the next pair's first byte following the commit fall directly. It then checks each register's value at the ports, and compares POR across reads, with a supply-low pulse and a write in between.

// File: rtl/synth_i2c_pkg.sv
// Shared types and constants for the synthesizer control slave.
// Assumes a 7-bit bus address whose upper five bits are fixed.
package synth_i2c_pkg;
    localparam logic [4:0] ADDR_FIXED = 5'b11000;

    // Control byte one field positions
    localparam int C1_PUMP  = 6;
    localparam int C1_TROUT = 5;
    localparam int C1_CPFLT = 4;
    localparam int C1_TUNEO = 0;
    // Control byte two field positions
    localparam int C2_BAND  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_st_t;

    typedef enum logic [1:0] {
        PAIR_NONE,
        PAIR_DIV,
        PAIR_CTL
    } pair_t;
endpackage

// File: rtl/i2c_line_cond.sv
// Synchronises SCL and SDA into the clk domain and derives single-cycle
// events: SCL rise, SCL fall, start and stop.
// Assumes both lines idle high and the bus is much slower than clk.
module i2c_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_pipe;
    logic [DEPTH-1:0] sda_pipe;

    // Shift both lines through the synchroniser chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[DEPTH-2:0], scl_i};
            sda_pipe <= {sda_pipe[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;

    // Pick the settled and previous samples out of the chains
    always_comb begin
        scl_now  = scl_pipe[DEPTH-2];
        scl_prev = scl_pipe[DEPTH-1];
        sda_now  = sda_pipe[DEPTH-2];
        sda_prev = sda_pipe[DEPTH-1];
    end

    // Event decode from current and previous samples
    always_comb begin
        sda_lvl   = sda_now;
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_evt = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_evt  = scl_now & scl_prev & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/synth_reg_bank.sv
// Assembles write data bytes into divider and control pairs. The type of a
// pair comes from bit 7 of its first byte; a pair is applied only when the
// acknowledge of its second byte ends. Assumes DIV_W = 8 + a width of at most 7.
module synth_reg_bank
    import synth_i2c_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int PORT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tel_clr,
    input  logic             byte_stb,
    input  logic [7:0]       byte_val,
    input  logic             ack_end,
    output logic [DIV_W-1:0] divider,
    output logic             pump_hi,
    output logic             test_route,
    output logic             cp_float,
    output logic             tune_off,
    output logic             band_b,
    output logic [PORT_N-1:0] port_on
);
    localparam int HI_W = DIV_W - 8;

    pair_t      pair_q;
    pair_t      armed_q;
    logic [6:0] hold_q;
    logic [7:0] lo_q;

    // Track pair progress and hold the first byte until the pair completes
    always_ff @(posedge clk) begin
        if (!rst_n || tel_clr) begin
            pair_q  <= PAIR_NONE;
            armed_q <= PAIR_NONE;
            hold_q  <= '0;
            lo_q    <= '0;
        end else if (byte_stb) begin
            if (pair_q == PAIR_NONE) begin
                hold_q <= byte_val[6:0];
                pair_q <= byte_val[7] ? PAIR_CTL : PAIR_DIV;
            end else begin
                lo_q    <= byte_val;
                armed_q <= pair_q;
                pair_q  <= PAIR_NONE;
            end
        end else if (ack_end) begin
            armed_q <= PAIR_NONE;
        end
    end

    // Apply a completed pair at the end of its second acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divider    <= '0;
            pump_hi    <= 1'b0;
            test_route <= 1'b0;
            cp_float   <= 1'b0;
            tune_off   <= 1'b0;
            band_b     <= 1'b0;
            port_on    <= '0;
        end else if (ack_end && armed_q == PAIR_DIV) begin
            divider <= {hold_q[HI_W-1:0], lo_q};
        end else if (ack_end && armed_q == PAIR_CTL) begin
            pump_hi    <= hold_q[C1_PUMP];
            test_route <= hold_q[C1_TROUT];
            cp_float   <= hold_q[C1_CPFLT];
            tune_off   <= hold_q[C1_TUNEO];
            band_b     <= lo_q[C2_BAND];
            port_on    <= lo_q[PORT_N-1:0];
        end
    end
endmodule

// File: rtl/synth_ctl_i2c.sv
// Two-wire control slave for a tuning synthesizer. Decodes the address,
// acknowledges bytes, passes write bytes to the register bank and shifts
// out a latched status byte on reads. Holds the power-on flag.
// Assumes clk oversamples SCL by at least eight to one.
module synth_ctl_i2c
    import synth_i2c_pkg::*;
#(
    parameter int DIV_W       = 15,
    parameter int PORT_N      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    input  logic [1:0]        ttl_in,
    input  logic [2:0]        adc_code,
    input  logic              lock_in,
    input  logic              supply_low,
    output logic              sda_drive_low,
    output logic [DIV_W-1:0]  divider,
    output logic              pump_hi,
    output logic              test_route,
    output logic              cp_float,
    output logic              tune_off,
    output logic              band_b,
    output logic [PORT_N-1:0] port_on
);
    localparam logic [3:0] CNT_LAST  = 4'd7;
    localparam logic [3:0] CNT_ACKW  = 4'd8;
    localparam logic [3:0] CNT_NINTH = 4'd9;

    logic sda_lvl, scl_rise_evt, scl_fall_evt, start_evt, stop_evt;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise_evt),
        .scl_fall (scl_fall_evt),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    bus_st_t    st;
    logic [3:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] status_q, tx_sr;
    logic       ack_pend, ack_drv, rd_req, rd_tel, tx_en, more, por;
    logic [7:0] rx_byte, stat_now;
    logic       addr_hit, byte_stb, ack_end;

    // Combine incoming bits, address match and status snapshot source
    always_comb begin
        rx_byte  = {rx_sr, sda_lvl};
        addr_hit = (rx_byte[7:3] == ADDR_FIXED) && (rx_byte[2:1] == addr_sel);
        stat_now = {por, lock_in, 1'b0, ttl_in, adc_code};
        byte_stb = (st == ST_WDATA) && scl_rise_evt && (bit_cnt == CNT_LAST);
        ack_end  = (st == ST_WDATA) && scl_fall_evt && (bit_cnt == CNT_NINTH);
    end

    // Bus protocol sequencer: address, acknowledge, write and read phases
    always_ff @(posedge clk) begin
        if (!rst_n || start_evt || stop_evt) begin
            st       <= (rst_n && start_evt) ? ST_ADDR : ST_IDLE;
            bit_cnt  <= '0;
            ack_pend <= 1'b0;
            ack_drv  <= 1'b0;
            tx_en    <= 1'b0;
            rd_tel   <= 1'b0;
            more     <= 1'b0;
            if (!rst_n) begin
                rx_sr    <= '0;
                rd_req   <= 1'b0;
                status_q <= '0;
                tx_sr    <= '1;
            end
        end else begin
            case (st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise_evt && bit_cnt < CNT_ACKW) begin
                        rx_sr   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == CNT_LAST) begin
                            ack_pend <= (st == ST_WDATA) || addr_hit;
                            if (st == ST_ADDR) begin
                                rd_req   <= rx_byte[0];
                                status_q <= stat_now;
                            end
                        end
                    end else if (scl_fall_evt && bit_cnt == CNT_ACKW) begin
                        bit_cnt <= CNT_NINTH;
                        ack_drv <= ack_pend;
                    end else if (scl_fall_evt && bit_cnt == CNT_NINTH) begin
                        bit_cnt <= '0;
                        ack_drv <= 1'b0;
                        if (st == ST_ADDR) begin
                            if (!ack_pend) begin
                                st <= ST_SKIP;
                            end else if (rd_req) begin
                                st     <= ST_RDATA;
                                tx_sr  <= status_q;
                                tx_en  <= 1'b1;
                                rd_tel <= 1'b1;
                            end else begin
                                st <= ST_WDATA;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise_evt && bit_cnt < CNT_ACKW) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall_evt) begin
                        if (bit_cnt == CNT_ACKW) begin
                            tx_en   <= 1'b0;
                            bit_cnt <= '0;
                            st      <= ST_RACK;
                        end else begin
                            tx_sr <= {tx_sr[6:0], 1'b1};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_evt) begin
                        more <= ~sda_lvl;
                    end else if (scl_fall_evt) begin
                        if (more) begin
                            tx_sr <= status_q;
                            tx_en <= 1'b1;
                            st    <= ST_RDATA;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Power-on flag: set by reset or supply-low, cleared when a read telegram stops
    always_ff @(posedge clk) begin
        if (!rst_n || supply_low) begin
            por <= 1'b1;
        end else if (stop_evt && rd_tel) begin
            por <= 1'b0;
        end
    end

    // SDA pull request from acknowledge or a zero status bit
    always_comb begin
        sda_drive_low = ack_drv | (tx_en & ~tx_sr[7]);
    end

    synth_reg_bank #(.DIV_W(DIV_W), .PORT_N(PORT_N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tel_clr   (start_evt | stop_evt),
        .byte_stb  (byte_stb),
        .byte_val  (rx_byte),
        .ack_end   (ack_end),
        .divider   (divider),
        .pump_hi   (pump_hi),
        .test_route(test_route),
        .cp_float  (cp_float),
        .tune_off  (tune_off),
        .band_b    (band_b),
        .port_on   (port_on)
    );
endmodule

// File: rtl/synth_ctl_i2c_chk.sv
// Property checker for the control slave, attached by bind.
// Assumes it observes the top's internal events and state as named there.
module synth_ctl_i2c_chk
    import synth_i2c_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int PORT_N = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall_evt,
    input logic              stop_evt,
    input logic [DIV_W-1:0]  divider,
    input logic [PORT_N-1:0] port_on,
    input logic              sda_drive_low,
    input logic              por,
    input bus_st_t           st,
    input logic [7:0]        status_q
);
    // R4
    div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(divider) |-> $past(scl_fall_evt));

    // R5
    port_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_on) |-> $past(scl_fall_evt));

    // R2
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> $past(scl_fall_evt));

    // R10
    por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por) |-> $past(stop_evt));

    // R8
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_drive_low);

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDATA) |=> $stable(status_q));
endmodule

bind synth_ctl_i2c synth_ctl_i2c_chk #(.DIV_W(DIV_W), .PORT_N(PORT_N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_fall_evt (scl_fall_evt),
    .stop_evt     (stop_evt),
    .divider      (divider),
    .port_on      (port_on),
    .sda_drive_low(sda_drive_low),
    .por          (por),
    .st           (st),
    .status_q     (status_q)
);

// File: tb/synth_ctl_i2c_tb.sv
// Self-checking bench: drives the bus as a host and compares port values
// with expectations computed from the requirements.
module synth_ctl_i2c_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int WDOG_LIM   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  addr_sel = 2'd2;
    logic [1:0]  ttl_in = 2'b10;
    logic [2:0]  adc_code = 3'b101;
    logic        lock_in = 1'b1;
    logic        supply_low = 1'b0;
    logic        sda_drive_low;
    logic [14:0] divider;
    logic        pump_hi, test_route, cp_float, tune_off, band_b;
    logic [2:0]  port_on;
    wire         sda_line = m_sda & ~sda_drive_low;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_ctl_i2c u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_sel(addr_sel), .ttl_in(ttl_in), .adc_code(adc_code),
        .lock_in(lock_in), .supply_low(supply_low),
        .sda_drive_low(sda_drive_low), .divider(divider),
        .pump_hi(pump_hi), .test_route(test_route), .cp_float(cp_float),
        .tune_off(tune_off), .band_b(band_b), .port_on(port_on)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_LIM && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIM);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1; waitq(2*Q);
        m_sda = 1'b0; waitq(2*Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b1; waitq(2*Q);
        m_sda = 1'b1; waitq(2*Q);
    endtask

    task automatic bit_io(input logic b, output logic s);
        m_sda = b; waitq(Q);
        m_scl = 1'b1; waitq(Q);
        s = sda_line; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(~host_ack, s);
    endtask

    function automatic logic [7:0] abyte(input logic [1:0] ma, input logic rw);
        return {5'b11000, ma, rw};
    endfunction

    function automatic logic [7:0] stat_exp(input logic p);
        return {p, lock_in, 1'b0, ttl_in, adc_code};
    endfunction

    task automatic write_pair(input logic [7:0] b1, input logic [7:0] b2);
        logic a;
        send_byte(b1, a); check("R3 first pair byte ack", a, 1'b1);
        send_byte(b2, a); check("R3 second pair byte ack", a, 1'b1);
    endtask

    initial begin
        logic        a;
        logic [7:0]  d;
        logic [14:0] v, prev;
        logic [7:0]  c1, c2;

        // R11: reset state, and no pull during reset even for a matching address
        waitq(6);
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        check("R11 no ack while in reset", a, 1'b0);
        bus_stop();
        check("R11 divider reset", divider, 15'd0);
        check("R11 controls reset", {pump_hi, test_route, cp_float, tune_off, band_b}, 5'd0);
        check("R11 ports reset", port_on, 3'd0);
        rst_n = 1'b1;
        waitq(8);
        check("R11 sda released after reset", sda_drive_low, 1'b0);

        // R2: address match sweep over every pin selection and address value
        for (int sel = 0; sel < 4; sel++) begin
            for (int ma = 0; ma < 4; ma++) begin
                addr_sel = sel[1:0];
                bus_start();
                send_byte(abyte(ma[1:0], 1'b0), a);
                bus_stop();
                check("R2 address ack matches selection", a, (sel == ma));
            end
        end
        addr_sel = 2'd2;
        bus_start();
        send_byte(8'h94, a);
        check("R2 wrong fixed bits not acked", a, 1'b0);
        send_byte(8'h01, a);
        send_byte(8'h23, a);
        bus_stop();
        check("R2 ignored telegram leaves divider", divider, 15'd0);

        // R7 R10: first read carries POR=1, the stop clears it
        bus_start();
        send_byte(abyte(2'd2, 1'b1), a);
        check("R7 read address ack", a, 1'b1);
        recv_byte(1'b0, d);
        bus_stop();
        check("R7 status with POR set", d, stat_exp(1'b1));
        bus_start();
        send_byte(abyte(2'd2, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R10 POR cleared by read stop", d, stat_exp(1'b0));

        // R8 R9: repeated status with inputs changing mid-telegram
        ttl_in = 2'b01; adc_code = 3'b011; lock_in = 1'b0;
        c1 = stat_exp(1'b0);
        bus_start();
        send_byte(abyte(2'd2, 1'b1), a);
        recv_byte(1'b1, d);
        check("R8 first repeated byte", d, c1);
        ttl_in = 2'b10; adc_code = 3'b110; lock_in = 1'b1;
        recv_byte(1'b1, d);
        check("R9 status latched across bytes", d, c1);
        recv_byte(1'b0, d);
        check("R9 third byte still latched", d, c1);
        recv_byte(1'b0, d);
        check("R8 released after nack", d, 8'hFF);
        bus_stop();

        // R4: divider sweep incl. limits, with atomicity check between bytes
        prev = divider;
        for (int k = 0; k < 18; k++) begin
            if (k == 0) v = 15'd256;
            else if (k == 1) v = 15'h7FFF;
            else v = 15'((k * 2053 + 311) & 16'h7FFF);
            bus_start();
            send_byte(abyte(2'd2, 1'b0), a);
            send_byte({1'b0, v[14:8]}, a);
            check("R3 divider high byte ack", a, 1'b1);
            check("R4 divider held between bytes", divider, prev);
            send_byte(v[7:0], a);
            bus_stop();
            check("R4 divider value", divider, v);
            prev = v;
        end

        // R5: control sweep over all port patterns and flag mixes
        for (int m = 0; m < 16; m++) begin
            c1 = {1'b1, m[0], m[1], m[2], 3'b000, m[3]};
            c2 = {3'b000, m[0] ^ m[3], 1'b0, m[2:0]};
            bus_start();
            send_byte(abyte(2'd2, 1'b0), a);
            write_pair(c1, c2);
            bus_stop();
            check("R5 control flags",
                  {pump_hi, test_route, cp_float, tune_off, band_b},
                  {m[0], m[1], m[2], m[3], m[0] ^ m[3]});
            check("R5 port enables", port_on, m[2:0]);
            check("R5 control pair leaves divider", divider, prev);
        end

        // R6: back-to-back pairs of alternating type in one telegram
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        write_pair(8'h12, 8'h34);
        write_pair(8'hC1, 8'h15);
        write_pair(8'h05, 8'hA6);
        bus_stop();
        check("R6 divider from last pair", divider, 15'h05A6);
        check("R6 control from middle pair", {pump_hi, test_route, band_b, port_on, tune_off}, {1'b1, 1'b0, 1'b1, 3'b101, 1'b1});

        // R6: half pair cut by stop is dropped
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        send_byte(8'h3F, a);
        bus_stop();
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        send_byte(8'hFF, a);
        check("R6 second byte after dropped half pair treated as new first", divider, 15'h05A6);
        bus_stop();
        check("R6 dropped half pair leaves divider", divider, 15'h05A6);
        check("R6 dropped control half leaves ports", port_on, 3'b101);

        // R12: repeated start discards half pair and restarts addressing
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        send_byte(8'h55, a);
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        check("R12 address after repeated start acked", a, 1'b1);
        write_pair(8'h80, 8'h02);
        bus_stop();
        check("R12 divider untouched by cut pair", divider, 15'h05A6);
        check("R12 new control pair applied", {pump_hi, band_b, tune_off, port_on}, {1'b0, 1'b0, 1'b0, 3'b010});

        // R10: supply-low sets POR, a write telegram does not clear it
        supply_low = 1'b1; waitq(3); supply_low = 1'b0;
        bus_start();
        send_byte(abyte(2'd2, 1'b0), a);
        write_pair(8'h01, 8'h00);
        bus_stop();
        bus_start();
        send_byte(abyte(2'd2, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R10 POR set by supply low survives write", d[7], 1'b1);
        check("R4 small divider value", divider, 15'h0100);
        bus_start();
        send_byte(abyte(2'd2, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R10 POR cleared after second read", d[7], 1'b0);

        // R1: bus idle after stop, no pull request
        waitq(8);
        check("R1 idle bus released", sda_drive_low, 1'b0);

        finish_run();
    end
endmodule